// File: doc/BRIEF.md
# Processor Sleep and Wakeup Controller

This block puts the processor core into its low-power state and brings it back. Three kinds of request start entry. The first is a one-cycle pulse from a wait-for-interrupt instruction. The second is a one-cycle pulse from a wait-for-event instruction. The third is a strobe at the return from an exception handler, and it counts only while the sleep-on-exit control bit is high. The controller stores which kind of request started the sleep. It refuses an instruction-driven request when an interrupt or event is already waiting. While the core sleeps, the controller judges each possible wake source against the way sleep was entered.

The block samples a pending, enable and priority-sufficient flag for every interrupt line. It also samples a set of dedicated event lines and a send-event-on-pend control bit. It drives three outputs: a sleep indication, a one-cycle wake pulse, and a flag. The flag tells the core whether, after waking, it must also start handling an interrupt or must simply carry on from the instruction that put it to sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `sleeping`, `wake_pulse` and `wake_take_irq` are 0 and `entry_mode` is 0 (none).
- R2: A RUN-cycle request causes `sleeping`=1 from the next cycle. The stored `entry_mode` is 1 for wait-for-interrupt, 2 for wait-for-event and 3 for handler return with `sleep_on_exit`=1. When requests arrive together, wait-for-event wins over wait-for-interrupt, and wait-for-interrupt wins over handler return. A handler return while `sleep_on_exit`=0 is ignored.
- R3: A wait-for-interrupt or wait-for-event request is dropped and the core stays running if, in the request cycle, any line is accepted or any event line is high. A line is accepted when its pending, enable and priority flags are all 1. A sleep-on-exit entry is never dropped.
- R4: In modes 1 and 3, any accepted line gives `wake_pulse`=1 in the next cycle with `wake_take_irq`=1. A pending line that is disabled or of insufficient priority does not wake the core, and neither does an event line.
- R5: In mode 2, a high event line gives a wake in the next cycle with `wake_take_irq`=0.
- R6: In mode 2 with `sev_on_pend`=0, an accepted line wakes the core with `wake_take_irq`=1. A pending line that is not accepted does not wake it.
- R7: In mode 2 with `sev_on_pend`=1, a pending bit that goes from 0 to 1 wakes the core. `wake_take_irq` is then 1 only if some line is accepted. A pending bit that was already high before the sleep does not wake the core.
- R8: `wake_pulse` lasts exactly one cycle. `sleeping` is 0 during that cycle and in the cycle after it, unless R10 applies.
- R9: `entry_mode` holds a non-zero value whenever `sleeping`=1 and reads 0 during the wake cycle.
- R10: A request that arrives in the wake cycle is kept and acted on in the following RUN cycle, so `sleeping` rises one cycle after that RUN cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| exc_return | input | 1 | Return-from-handler strobe |
| sleep_on_exit | input | 1 | Enables sleep entry at handler return |
| sev_on_pend | input | 1 | A newly pending line counts as a wake event in wait-for-event mode |
| irq_pending | input | N_IRQ | Per-line pending flag |
| irq_enable | input | N_IRQ | Per-line enable flag |
| irq_prio_ok | input | N_IRQ | Per-line flag: priority high enough to preempt |
| evt_line | input | N_EVT | Dedicated wake event lines |
| sleeping | output | 1 | Core is in the low-power state |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_take_irq | output | 1 | Valid with wake_pulse: core must take the interrupt |
| entry_mode | output | 2 | Stored entry kind: 0 none, 1 WFI, 2 WFE, 3 sleep-on-exit |

## Verification
A corrupted state register shows at the ports within one cycle. `sleeping` and `wake_pulse` are decoded straight from the state, and `entry_mode` is the stored mode register. A stuck or wrong mode shows in the first sleep cycle, either as a wake that R4 or R6 forbids or as a wake that never comes. A broken pending-edge history shows only in wait-for-event sleeps with send-on-pend set, as a wake from a bit that stayed high, or as a missed wake, one cycle after the bit changes.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_WFI  = 2'd1,
        MODE_WFE  = 2'd2,
        MODE_EXIT = 2'd3
    } entry_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic hit;
        logic take;
    } wake_dec_t;

    // Arbitration among simultaneous requests: WFE, then WFI, then handler return.
    function automatic entry_mode_e pick_mode(input logic wfe, input logic wfi,
                                              input logic ret, input logic soe);
        if (wfe)             return MODE_WFE;
        else if (wfi)        return MODE_WFI;
        else if (ret && soe) return MODE_EXIT;
        else                 return MODE_NONE;
    endfunction

    function automatic logic is_instr_mode(input entry_mode_e m);
        return (m == MODE_WFI) || (m == MODE_WFE);
    endfunction

endpackage

// File: rtl/slpwk_entry.sv
module slpwk_entry
    import slpwk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wfi_req,
    input  logic        wfe_req,
    input  logic        exc_return,
    input  logic        sleep_on_exit,
    input  logic        any_accepted,
    input  logic        any_evt,
    input  logic        in_run,
    input  logic        in_wake,
    output logic        go,
    output entry_mode_e go_mode
);

    entry_mode_e live_mode;
    entry_mode_e defer_q;
    entry_mode_e eff_mode;
    logic        blocked;

    always_comb begin
        live_mode = pick_mode(wfe_req, wfi_req, exc_return, sleep_on_exit);
        eff_mode  = (defer_q != MODE_NONE) ? defer_q : live_mode;
        blocked   = is_instr_mode(eff_mode) && (any_accepted || any_evt);
        go        = in_run && (eff_mode != MODE_NONE) && !blocked;
        go_mode   = eff_mode;
    end

    // A request seen during the wake cycle is parked for the next RUN cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            defer_q <= MODE_NONE;
        end else if (in_wake) begin
            if (live_mode != MODE_NONE)
                defer_q <= live_mode;
        end else if (in_run) begin
            defer_q <= MODE_NONE;
        end
    end

endmodule

// File: rtl/slpwk_wake_qual.sv
module slpwk_wake_qual
    import slpwk_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_EVT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_pending,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic [N_IRQ-1:0] irq_prio_ok,
    input  logic [N_EVT-1:0] evt_line,
    input  logic             sev_on_pend,
    input  entry_mode_e      mode,
    output logic             any_accepted,
    output logic             any_evt,
    output wake_dec_t        dec
);

    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] accepted_vec;
    logic [N_IRQ-1:0] rise_vec;
    logic             any_rise;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= irq_pending;
    end

    generate
        for (genvar i = 0; i < N_IRQ; i++) begin : g_line
            assign accepted_vec[i] = irq_pending[i] & irq_enable[i] & irq_prio_ok[i];
            assign rise_vec[i]     = irq_pending[i] & ~pend_q[i];
        end
    endgenerate

    assign any_accepted = |accepted_vec;
    assign any_rise     = |rise_vec;
    assign any_evt      = |evt_line;

    always_comb begin
        dec = '0;
        unique case (mode)
            MODE_WFI, MODE_EXIT: begin
                dec.hit  = any_accepted;
                dec.take = any_accepted;
            end
            MODE_WFE: begin
                dec.hit  = any_accepted || any_evt || (sev_on_pend && any_rise);
                dec.take = any_accepted;
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slpwk_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_EVT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             exc_return,
    input  logic             sleep_on_exit,
    input  logic             sev_on_pend,
    input  logic [N_IRQ-1:0] irq_pending,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic [N_IRQ-1:0] irq_prio_ok,
    input  logic [N_EVT-1:0] evt_line,
    output logic             sleeping,
    output logic             wake_pulse,
    output logic             wake_take_irq,
    output logic [1:0]       entry_mode
);

    ctl_state_e  state_q;
    entry_mode_e mode_q;
    logic        take_q;
    logic        go;
    entry_mode_e go_mode;
    logic        any_accepted;
    logic        any_evt;
    wake_dec_t   dec;

    slpwk_entry u_entry (
        .clk          (clk),
        .rst          (rst),
        .wfi_req      (wfi_req),
        .wfe_req      (wfe_req),
        .exc_return   (exc_return),
        .sleep_on_exit(sleep_on_exit),
        .any_accepted (any_accepted),
        .any_evt      (any_evt),
        .in_run       (state_q == ST_RUN),
        .in_wake      (state_q == ST_WAKE),
        .go           (go),
        .go_mode      (go_mode)
    );

    slpwk_wake_qual #(
        .N_IRQ(N_IRQ),
        .N_EVT(N_EVT)
    ) u_qual (
        .clk         (clk),
        .rst         (rst),
        .irq_pending (irq_pending),
        .irq_enable  (irq_enable),
        .irq_prio_ok (irq_prio_ok),
        .evt_line    (evt_line),
        .sev_on_pend (sev_on_pend),
        .mode        (mode_q),
        .any_accepted(any_accepted),
        .any_evt     (any_evt),
        .dec         (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_NONE;
            take_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (go) begin
                        state_q <= ST_SLEEP;
                        mode_q  <= go_mode;
                    end
                end
                ST_SLEEP: begin
                    if (dec.hit) begin
                        state_q <= ST_WAKE;
                        mode_q  <= MODE_NONE;
                        take_q  <= dec.take;
                    end
                end
                default: begin
                    state_q <= ST_RUN;
                    take_q  <= 1'b0;
                end
            endcase
        end
    end

    assign sleeping      = (state_q == ST_SLEEP);
    assign wake_pulse    = (state_q == ST_WAKE);
    assign wake_take_irq = take_q;
    assign entry_mode    = mode_q;

endmodule

// File: rtl/slpwk_chk.sv
module slpwk_chk #(
    parameter int N_IRQ = 8,
    parameter int N_EVT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wfi_req,
    input logic             wfe_req,
    input logic             exc_return,
    input logic             sleep_on_exit,
    input logic             sev_on_pend,
    input logic [N_IRQ-1:0] irq_pending,
    input logic [N_IRQ-1:0] irq_enable,
    input logic [N_IRQ-1:0] irq_prio_ok,
    input logic [N_EVT-1:0] evt_line,
    input logic             sleeping,
    input logic             wake_pulse,
    input logic             wake_take_irq,
    input logic [1:0]       entry_mode
);

    logic acc;
    logic evt_any;
    assign acc     = |(irq_pending & irq_enable & irq_prio_ok);
    assign evt_any = |evt_line;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!sleeping && !wake_pulse && !wake_take_irq && entry_mode == 2'd0));

    a_r3_blocked_entry: assert property (@(posedge clk) disable iff (rst)
        (!sleeping && !wake_pulse && !$past(wake_pulse) && (wfi_req || wfe_req)
         && (acc || evt_any)) |=> !sleeping);

    a_r4_accepted_wakes: assert property (@(posedge clk) disable iff (rst)
        (sleeping && (entry_mode == 2'd1 || entry_mode == 2'd3) && acc)
        |=> (wake_pulse && wake_take_irq));

    a_r4_no_false_wake: assert property (@(posedge clk) disable iff (rst)
        (sleeping && entry_mode != 2'd2 && !acc) |=> sleeping);

    a_r5_event_wakes: assert property (@(posedge clk) disable iff (rst)
        (sleeping && entry_mode == 2'd2 && evt_any) |=> wake_pulse);

    a_r7_take_with_wake: assert property (@(posedge clk) disable iff (rst)
        wake_take_irq |-> wake_pulse);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> (!wake_pulse && !sleeping));

    a_r9_mode_cleared: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (entry_mode == 2'd0));

    a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> (entry_mode != 2'd0));

endmodule

bind sleep_wake_ctrl slpwk_chk #(.N_IRQ(N_IRQ), .N_EVT(N_EVT)) u_chk (.*);

// File: tb/sleep_wake_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb;

    localparam int N_IRQ = 8;
    localparam int N_EVT = 2;
    localparam int VW    = 31;
    localparam int NVEC  = 12;

    logic             clk = 1'b0;
    logic             rst;
    logic             wfi_req, wfe_req, exc_return, sleep_on_exit, sev_on_pend;
    logic [N_IRQ-1:0] irq_pending, irq_enable, irq_prio_ok;
    logic [N_EVT-1:0] evt_line;
    logic             sleeping, wake_pulse, wake_take_irq;
    logic [1:0]       entry_mode;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sleep_wake_ctrl #(.N_IRQ(N_IRQ), .N_EVT(N_EVT)) u_dut (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .exc_return(exc_return), .sleep_on_exit(sleep_on_exit),
        .sev_on_pend(sev_on_pend), .irq_pending(irq_pending),
        .irq_enable(irq_enable), .irq_prio_ok(irq_prio_ok), .evt_line(evt_line),
        .sleeping(sleeping), .wake_pulse(wake_pulse),
        .wake_take_irq(wake_take_irq), .entry_mode(entry_mode)
    );

    // kind[30:29] sev[28] pend[27:20] en[19:12] prio[11:4] evt[3:2] wake[1] take[0]
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {2'd1, 1'b0, 8'h01, 8'h01, 8'h01, 2'b00, 1'b1, 1'b1},  // R4 WFI accepted
        {2'd1, 1'b0, 8'h02, 8'h00, 8'h02, 2'b00, 1'b0, 1'b0},  // R4 WFI disabled
        {2'd1, 1'b0, 8'h00, 8'h00, 8'h00, 2'b01, 1'b0, 1'b0},  // R4 WFI event ignored
        {2'd3, 1'b0, 8'h04, 8'h04, 8'h04, 2'b00, 1'b1, 1'b1},  // R4 exit accepted
        {2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 2'b10, 1'b1, 1'b0},  // R5 WFE event line
        {2'd2, 1'b0, 8'h08, 8'h00, 8'h08, 2'b00, 1'b0, 1'b0},  // R6 disabled no wake
        {2'd2, 1'b0, 8'h08, 8'h08, 8'h08, 2'b00, 1'b1, 1'b1},  // R6 accepted
        {2'd2, 1'b1, 8'h10, 8'h00, 8'h00, 2'b00, 1'b1, 1'b0},  // R7 disabled new pend
        {2'd2, 1'b1, 8'h20, 8'h20, 8'h00, 2'b00, 1'b1, 1'b0},  // R7 low prio new pend
        {2'd2, 1'b1, 8'h40, 8'h40, 8'h40, 2'b00, 1'b1, 1'b1},  // R7 accepted
        {2'd2, 1'b0, 8'h40, 8'h40, 8'h00, 2'b00, 1'b0, 1'b0},  // R6 low prio no wake
        {2'd1, 1'b0, 8'h80, 8'h80, 8'h00, 2'b00, 1'b0, 1'b0}   // R4 low prio no wake
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        wfi_req = 0; wfe_req = 0; exc_return = 0; sleep_on_exit = 0; sev_on_pend = 0;
        irq_pending = '0; irq_enable = '0; irq_prio_ok = '0; evt_line = '0;
    endtask

    // Drive a request for one cycle; on return the posedge has been taken.
    task automatic request(input logic [1:0] kind);
        @(negedge clk);
        wfi_req       = (kind == 2'd1);
        wfe_req       = (kind == 2'd2);
        exc_return    = (kind == 2'd3);
        sleep_on_exit = (kind == 2'd3);
        @(negedge clk);
        wfi_req = 0; wfe_req = 0; exc_return = 0; sleep_on_exit = 0;
    endtask

    // Wake any mode with line 0 accepted and return to RUN.
    task automatic recover();
        irq_pending = 8'h01; irq_enable = 8'h01; irq_prio_ok = 8'h01; evt_line = '0;
        @(negedge clk);
        clear_in();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 sleeping in reset", {31'd0, sleeping}, 0);
        chk("R1 mode in reset", {30'd0, entry_mode}, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 outputs after reset", {29'd0, sleeping, wake_pulse, wake_take_irq}, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            request(v[30:29]);
            chk("R2 sleep entered", {31'd0, sleeping}, 1);
            chk("R2 mode stored", {30'd0, entry_mode}, {30'd0, v[30:29]});
            sev_on_pend = v[28];
            irq_pending = v[27:20]; irq_enable = v[19:12]; irq_prio_ok = v[11:4];
            evt_line = v[3:2];
            @(negedge clk);
            if (v[1]) begin
                chk("R4-7 wake pulse", {31'd0, wake_pulse}, 1);
                chk("R4-7 take flag", {31'd0, wake_take_irq}, {31'd0, v[0]});
                chk("R9 mode cleared at wake", {30'd0, entry_mode}, 0);
                clear_in();
                @(negedge clk);
                chk("R8 one-cycle pulse", {30'd0, wake_pulse, sleeping}, 0);
            end else begin
                chk("R4 R6 stays asleep", {30'd0, sleeping, wake_pulse}, 2'b10);
                recover();
            end
        end

        // R2 handler return without sleep-on-exit is ignored
        @(negedge clk);
        exc_return = 1;
        @(negedge clk);
        exc_return = 0;
        chk("R2 exit ignored without control bit", {31'd0, sleeping}, 0);

        // R2 priority: WFE over WFI
        @(negedge clk);
        wfi_req = 1; wfe_req = 1;
        @(negedge clk);
        wfi_req = 0; wfe_req = 0;
        chk("R2 WFE wins priority", {30'd0, entry_mode}, 2);
        recover();

        // R3 blocked WFI with accepted pending
        irq_pending = 8'h02; irq_enable = 8'h02; irq_prio_ok = 8'h02;
        request(2'd1);
        chk("R3 WFI blocked by pending", {31'd0, sleeping}, 0);
        clear_in();
        // R3 blocked WFE with event line
        evt_line = 2'b01;
        request(2'd2);
        chk("R3 WFE blocked by event", {31'd0, sleeping}, 0);
        clear_in();
        // R3 sleep-on-exit not blocked (then wakes at once, R4)
        irq_pending = 8'h02; irq_enable = 8'h02; irq_prio_ok = 8'h02;
        request(2'd3);
        chk("R3 exit entry not blocked", {31'd0, sleeping}, 1);
        @(negedge clk);
        chk("R4 exit wake with take", {30'd0, wake_pulse, wake_take_irq}, 2'b11);
        clear_in();
        @(negedge clk);
        @(negedge clk);

        // R7 level of an old disabled pending bit does not wake
        irq_pending = 8'h04;
        sev_on_pend = 1;
        repeat (2) @(negedge clk);
        request(2'd2);
        chk("R7 entry with old pend", {31'd0, sleeping}, 1);
        repeat (3) @(negedge clk);
        chk("R7 old pending level no wake", {31'd0, sleeping}, 1);
        irq_pending = 8'h0C;
        @(negedge clk);
        chk("R7 new pend wakes no take", {30'd0, wake_pulse, wake_take_irq}, 2'b10);
        clear_in();
        @(negedge clk);

        // R10 request during wake cycle is deferred
        request(2'd1);
        irq_pending = 8'h01; irq_enable = 8'h01; irq_prio_ok = 8'h01;
        @(negedge clk);
        chk("R10 in wake cycle", {31'd0, wake_pulse}, 1);
        clear_in();
        wfi_req = 1;
        @(negedge clk);
        wfi_req = 0;
        chk("R10 RUN cycle after wake", {31'd0, sleeping}, 0);
        @(negedge clk);
        chk("R10 deferred sleep taken", {29'd0, sleeping, entry_mode}, {29'd0, 1'b1, 2'd1});
        recover();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule